// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block keeps the 32-bit status/control word of a scalar floating-point unit. Software writes the word through a single-cycle write strobe, and only a fixed set of writable bits is kept. Software reads it combinationally. A read returns the stored control bits with the live accumulated exception flags merged in.

The arithmetic units see a 2-bit rounding mode driven by the block. They report exception events each cycle on a 5-bit flag input, and the block accumulates these as sticky flags. A write that moves the 3-bit rounding field to a code the units cannot honour raises an error output for one cycle, and the units keep the rounding mode they had before. Every write also reloads the sticky flags from the trap-enable field of the written value.

Top module: `fpsr_unit`

## Requirements
- R1: After reset `rd_data_o` is 0, `rnd_mode_o` is 0 (nearest even) and `rnd_err_o` is 0.
- R2: A write stores `wr_data_i` ANDed with the writable mask 0xF000_1FFF. Bits 31:28 and 12:0 are kept, and bits 27:13 always read as zero.
- R3: `rd_data_o` equals the stored word ORed with the sticky flags placed in bits 4:0 (bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact).
- R4: The rounding field is in bits 12:10. Codes 0, 1, 2 and 3 drive `rnd_mode_o` to 0 (nearest even), 1 (toward zero), 2 (toward +inf) and 3 (toward -inf), visible from the cycle after the write.
- R5: A write that changes the rounding field to an unsupported code (4 to 7) sets `rnd_err_o` to 1 in the following cycle only and leaves `rnd_mode_o` unchanged.
- R6: `rnd_mode_o` and `rnd_err_o` react only when a write changes the stored rounding field. Rewriting the same code, even an unsupported one, raises no error and leaves the mode unchanged.
- R7: Every write loads the sticky flags with bits 9:5 of the written value (trap-enable field, same flag order as R3).
- R8: In cycles without a write, `exc_flags_i` is ORed into the sticky flags. Set flags stay set until a write or a reset.
- R9: When a write and `exc_flags_i` occur in the same cycle, the write wins and that cycle's `exc_flags_i` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| exc_flags_i | input | 5 | Exception events from the arithmetic units |
| rd_data_o | output | 32 | Software read data (stored word with live flags) |
| rnd_mode_o | output | 2 | Rounding mode to the arithmetic units |
| rnd_err_o | output | 1 | Unsupported rounding code written (one cycle) |

## Verification
The assertions check four things on every cycle:
- the stored word holds still between writes;
- sticky flags never clear without a write, and a write reloads them;
- the rounding mode holds unless the field changes;
- an error cycle always comes with the previous mode kept.

Only the bench scenarios can show the exact read value for a given history. They also cover the write-over-event priority, the one-cycle width of the error pulse, and the silent rewrite of an unsupported code.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int DATA_W   = 32;
  localparam int FLAG_W   = 5;
  localparam int FLAG_LSB = 0;
  localparam int TRAP_LSB = 5;
  localparam int RND_W    = 3;
  localparam int RND_LSB  = 10;
  localparam int MODE_W   = 2;
  localparam logic [DATA_W-1:0] WR_MASK = 32'hF000_1FFF;

  typedef enum logic [MODE_W-1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_TO_ZERO   = 2'd1,
    RND_POS_INF   = 2'd2,
    RND_NEG_INF   = 2'd3
  } rnd_mode_e;

  function automatic logic rnd_code_ok(logic [RND_W-1:0] code);
    return code < RND_W'(1 << MODE_W);
  endfunction
endpackage

// File: rtl/fpsr_store.sv
module fpsr_store #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (wr_en_i) word_o <= wr_data_i & MASK;
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(word_o));
  assert_unwritable_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_o & ~MASK) == '0);
endmodule

// File: rtl/fpsr_sticky.sv
module fpsr_sticky #(
  parameter int FLAG_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [FLAG_W-1:0] load_i,
  input  logic [FLAG_W-1:0] exc_i,
  output logic [FLAG_W-1:0] flags_o
);
  // software write overrides same-cycle events
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_o <= '0;
    else if (wr_en_i) flags_o <= load_i;
    else              flags_o <= flags_o | exc_i;
  end

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
  assert_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (flags_o == $past(load_i)));
endmodule

// File: rtl/fpsr_rnd.sv
module fpsr_rnd
  import fpsr_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] new_code_i,
  input  logic [CODE_W-1:0] old_code_i,
  output rnd_mode_e         mode_o,
  output logic              err_o
);
  logic changed, code_ok;

  assign changed = wr_en_i && (new_code_i != old_code_i);
  assign code_ok = rnd_code_ok(new_code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= RND_NEAR_EVEN;
      err_o  <= 1'b0;
    end else begin
      err_o <= changed && !code_ok;
      if (changed && code_ok) mode_o <= rnd_mode_e'(new_code_i[MODE_W-1:0]);
    end
  end

  assert_mode_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (new_code_i != old_code_i)) |=> ($stable(mode_o) && !err_o));
  assert_err_keeps_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !rnd_code_ok(new_code_i) |=> $stable(mode_o));
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = WR_MASK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [FLAG_W-1:0] exc_flags_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [MODE_W-1:0] rnd_mode_o,
  output logic              rnd_err_o
);
  logic [DATA_W-1:0] word;
  logic [FLAG_W-1:0] flags;
  rnd_mode_e         mode;

  fpsr_store #(.DATA_W(DATA_W), .MASK(MASK)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .word_o(word)
  );

  fpsr_sticky #(.FLAG_W(FLAG_W)) u_sticky (
    .clk_i, .rst_ni, .wr_en_i,
    .load_i (wr_data_i[TRAP_LSB +: FLAG_W]),
    .exc_i  (exc_flags_i),
    .flags_o(flags)
  );

  fpsr_rnd #(.CODE_W(RND_W)) u_rnd (
    .clk_i, .rst_ni, .wr_en_i,
    .new_code_i(wr_data_i[RND_LSB +: RND_W]),
    .old_code_i(word[RND_LSB +: RND_W]),
    .mode_o    (mode),
    .err_o     (rnd_err_o)
  );

  assign rnd_mode_o = mode;
  assign rd_data_o  = word | (DATA_W'(flags) << FLAG_LSB);

  assert_read_has_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & word) == word);
endmodule

// File: tb/sim_fpsr_unit.sv
`timescale 1ns/1ps
module sim_fpsr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4:0]  exc = '0;
  logic [31:0] rd_data;
  logic [1:0]  rnd_mode;
  logic        rnd_err;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  fpsr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .exc_flags_i(exc), .rd_data_o(rd_data), .rnd_mode_o(rnd_mode), .rnd_err_o(rnd_err)
  );

  typedef struct packed {
    logic [31:0] wd;
    logic [31:0] rd;
    logic [1:0]  mode;
    logic        err;
  } vec_t;

  // applied in order from reset; expectations follow R2..R7
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0400, 32'h0000_0400, 2'd1, 1'b0},
    '{32'h0000_0825, 32'h0000_0825, 2'd2, 1'b0},
    '{32'hFFFF_FFFF, 32'hF000_1FFF, 2'd2, 1'b1},
    '{32'h0000_1000, 32'h0000_1000, 2'd2, 1'b1},
    '{32'h0000_1000, 32'h0000_1000, 2'd2, 1'b0},
    '{32'h0000_1400, 32'h0000_1400, 2'd2, 1'b1},
    '{32'h0000_0C00, 32'h0000_0C00, 2'd3, 1'b0},
    '{32'h0000_03E0, 32'h0000_03FF, 2'd0, 1'b0},
    '{32'h0ABC_0000, 32'h0000_0000, 2'd0, 1'b0},
    '{32'h5000_0140, 32'h5000_014A, 2'd0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input logic [4:0] e);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; exc = e;
    @(negedge clk);
    wr_en = 1'b0; exc = '0;
  endtask

  task automatic pulse_exc(input logic [4:0] e);
    @(negedge clk);
    exc = e;
    @(negedge clk);
    exc = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd", rd_data, 32'h0);
    check("R1 mode", 32'(rnd_mode), 32'h0);
    check("R1 err", 32'(rnd_err), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].wd, 5'h0);
      check($sformatf("R2/R3/R7 vec%0d rd", i), rd_data, VECS[i].rd);
      check($sformatf("R4/R6 vec%0d mode", i), 32'(rnd_mode), 32'(VECS[i].mode));
      check($sformatf("R5/R6 vec%0d err", i), 32'(rnd_err), 32'(VECS[i].err));
    end

    // R5: error pulse lasts one cycle
    do_write(32'h0000_1800, 5'h0);
    check("R5 err set", 32'(rnd_err), 32'h1);
    check("R5 mode kept", 32'(rnd_mode), 32'h0);
    @(negedge clk);
    check("R5 err one cycle", 32'(rnd_err), 32'h0);

    // R8: sticky accumulation between writes
    do_write(32'h0000_0800, 5'h0);
    check("R4 toward +inf", 32'(rnd_mode), 32'h2);
    pulse_exc(5'b00100);
    check("R8 first event", rd_data, 32'h0000_0804);
    pulse_exc(5'b00001);
    check("R8 second event", rd_data, 32'h0000_0805);
    repeat (3) @(negedge clk);
    check("R8 flags stay", rd_data, 32'h0000_0805);
    check("R8 mode untouched", 32'(rnd_mode), 32'h2);

    // R9: write wins over same-cycle events
    do_write(32'h0000_0800, 5'h1F);
    check("R9 write priority", rd_data, 32'h0000_0800);
    check("R6 same code no err", 32'(rnd_err), 32'h0);

    // R1: reset mid-run
    pulse_exc(5'h10);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset rd", rd_data, 32'h0);
    check("R1 reset mode", 32'(rnd_mode), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule